// File: doc/BRIEF.md
# Ethernet receive destination-address filter

This block decides, frame by frame, whether an incoming Ethernet frame should be kept. A receive datapath presents the destination-address bytes one per strobe after a start-of-frame pulse. The block checks the address against a programmable station address and a 64-entry multicast hash table, and classifies it as broadcast, station match or multicast. It then combines that address verdict with the runt and error indications given at end of frame to produce a final keep/drop decision.

The multicast hash index is taken from a CRC-32 computed over the destination bytes as they arrive. No extra pass over the address is needed. The station address, hash table and a six-bit accept-mode field are inputs that software may change at any time. They are captured at each start-of-frame, so a change takes effect on the next frame and never part-way through one.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `addr_valid`, `addr_hit`, `cls_bcast`, `cls_phys`, `cls_mcast`, `frame_done` and `frame_accept` are all 0.
- R2: Address bytes are taken on `da_valid` after `sof`. The first byte taken is address bits 7:0 and the sixth is bits 47:40. `addr_valid` rises one clock after the sixth byte is taken. It and the address outputs then hold unchanged until the next `sof`, and further `da_valid` bytes are ignored.
- R3: An all-ones address sets `cls_bcast` only. It passes (`addr_hit`) exactly when mode bit 3 is set, whatever the hash table holds.
- R4: Any other address with bit 0 of the first byte set sets `cls_mcast` only. It passes exactly when mode bit 2 is set and the selected hash-table bit is 1.
- R5: The hash index is bits 31:26 of a CRC-32 over the six address bytes. The CRC is reflected, with polynomial 0xEDB88320, start value all ones, least significant bit of each byte first, and no final inversion. Index k selects `hash_word0[k]` for k < 32 and `hash_word1[k-32]` otherwise.
- R6: With both hash words all ones and mode bit 2 set, every multicast address passes.
- R7: An address with bit 0 of the first byte clear sets `cls_phys` exactly when it equals `station_addr`. It passes when mode bit 0 (promiscuous) is set, or when mode bit 1 is set and it matches.
- R8: A frame whose `eof_runt` is 1 at the `eof` strobe has `frame_accept` 0 unless mode bit 4 is set.
- R9: A frame whose `eof_err` is 1 at the `eof` strobe has `frame_accept` 0 unless mode bit 5 is set.
- R10: `frame_done` rises one clock after the first `eof` strobe of a frame. `frame_accept` is then `addr_hit` gated by R8 and R9, and both hold until the next `sof`. An `eof` that comes before `addr_valid` gives `frame_accept` 0.
- R11: `accept_mode`, `hash_word0`, `hash_word1` and `station_addr` are sampled at `sof`. Changing them during a frame does not affect that frame's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse; clears the previous verdict and samples the configuration |
| da_valid | input | 1 | Destination byte strobe |
| da_byte | input | 8 | Destination address byte |
| eof | input | 1 | End-of-frame strobe |
| eof_runt | input | 1 | Frame was shorter than the minimum, valid with `eof` |
| eof_err | input | 1 | Frame had a receive error, valid with `eof` |
| station_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| hash_word0 | input | 32 | Hash table bits 31:0 |
| hash_word1 | input | 32 | Hash table bits 63:32 |
| accept_mode | input | 6 | 0 promiscuous, 1 station, 2 multicast, 3 broadcast, 4 runt, 5 errored |
| addr_valid | output | 1 | Address verdict is valid |
| addr_hit | output | 1 | Address passed the filter |
| cls_bcast | output | 1 | Address is broadcast |
| cls_phys | output | 1 | Address equals the station address |
| cls_mcast | output | 1 | Address is multicast (not broadcast) |
| frame_done | output | 1 | Final verdict is valid |
| frame_accept | output | 1 | Frame is kept |

## Verification
The bench sweeps all 64 accept-mode values against broadcast, station-match, foreign unicast and two multicast addresses, each with every runt/error combination. A design that mixed up the mode bit positions, or let broadcast fall into the hash lookup, would mis-pass some of those frames. For several multicast addresses it programs a table holding only the computed index bit, and then a table holding every bit except it. A wrong CRC polynomial, bit order, inversion or word split would flip one of those two verdicts. It also changes the mode mid-frame, sends a seventh address byte and ends a frame early; a design that applied configuration immediately, or kept shifting bytes, or accepted without an address verdict would then change a verdict that should not move.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
   localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

   localparam int MB_PROMISC = 0;
   localparam int MB_STATION = 1;
   localparam int MB_MCAST   = 2;
   localparam int MB_BCAST   = 3;
   localparam int MB_RUNT    = 4;
   localparam int MB_ERR     = 5;
   localparam int MODE_W     = 6;

   typedef struct packed {
      logic bcast;
      logic phys;
      logic mcast;
   } rxf_class_t;
endpackage

// File: rtl/rxf_crc_step.sv
module rxf_crc_step #(
   parameter int DW = 8
) (
   input  logic [31:0]   crc_in,
   input  logic [DW-1:0] din,
   output logic [31:0]   crc_out
);
   import rxf_pkg::*;

   if (DW < 1 || DW > 32) begin : g_bad_dw
      $error("rxf_crc_step: DW must be 1..32");
   end

   logic [DW:0][31:0] st;

   assign st[0] = crc_in ^ {{(32-DW){1'b0}}, din};

   for (genvar k = 0; k < DW; k++) begin : g_bit
      assign st[k+1] = st[k][0] ? ((st[k] >> 1) ^ CRC_POLY) : (st[k] >> 1);
   end

   assign crc_out = st[DW];
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify #(
   parameter int NBYTES = 6,
   parameter int IDX_W  = 6,
   localparam int AW    = 8 * NBYTES,
   localparam int HW    = 1 << IDX_W
) (
   input  logic [AW-1:0]    da,
   input  logic [AW-1:0]    station,
   input  logic [HW-1:0]    table_bits,
   input  logic [3:0]       mode,
   input  logic [IDX_W-1:0] idx,
   output rxf_pkg::rxf_class_t cls,
   output logic             hit
);
   import rxf_pkg::*;

   logic is_bc, is_grp, is_uc, is_me;

   always_comb begin
      is_bc  = &da;
      is_grp = da[0] & ~is_bc;
      is_uc  = ~da[0];
      is_me  = is_uc & (da == station);
      cls.bcast = is_bc;
      cls.mcast = is_grp;
      cls.phys  = is_me;
      hit = (is_bc  & mode[MB_BCAST])
          | (is_grp & mode[MB_MCAST] & table_bits[idx])
          | (is_uc  & (mode[MB_PROMISC] | (mode[MB_STATION] & is_me)));
   end

   always_comb begin
      assert ($onehot0({cls.bcast, cls.phys, cls.mcast}))
         else $error("AST_CLASS_EXCLUSIVE"); // R3
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
   parameter int NBYTES = 6,
   parameter int IDX_W  = 6,
   localparam int AW    = 8 * NBYTES,
   localparam int HW    = 1 << IDX_W,
   localparam int WW    = HW / 2,
   localparam int CNT_W = $clog2(NBYTES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof,
   input  logic          da_valid,
   input  logic [7:0]    da_byte,
   input  logic          eof,
   input  logic          eof_runt,
   input  logic          eof_err,
   input  logic [AW-1:0] station_addr,
   input  logic [WW-1:0] hash_word0,
   input  logic [WW-1:0] hash_word1,
   input  logic [5:0]    accept_mode,
   output logic          addr_valid,
   output logic          addr_hit,
   output logic          cls_bcast,
   output logic          cls_phys,
   output logic          cls_mcast,
   output logic          frame_done,
   output logic          frame_accept
);
   import rxf_pkg::*;

   if (NBYTES < 1) begin : g_bad_bytes
      $error("rx_addr_filter: NBYTES must be at least 1");
   end
   if (IDX_W < 2 || IDX_W > 32) begin : g_bad_idx
      $error("rx_addr_filter: IDX_W must be 2..32");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [AW-1:0]     da_q, da_next;
   logic [31:0]       crc_q, crc_next;
   logic [MODE_W-1:0] mode_q;
   logic [HW-1:0]     tbl_q;
   logic [AW-1:0]     sta_q;
   logic              take, last;
   rxf_class_t        cls_d;
   logic              hit_d, gate_ok;

   assign take = da_valid && !sof && (cnt_q < CNT_W'(NBYTES));
   assign last = take && (cnt_q == CNT_W'(NBYTES - 1));

   always_comb begin
      da_next = da_q;
      da_next[8*cnt_q +: 8] = da_byte;
   end

   rxf_crc_step #(.DW(8)) u_crc (
      .crc_in (crc_q),
      .din    (da_byte),
      .crc_out(crc_next)
   );

   rxf_classify #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_cls (
      .da        (da_next),
      .station   (sta_q),
      .table_bits(tbl_q),
      .mode      (mode_q[3:0]),
      .idx       (crc_next[31 -: IDX_W]),
      .cls       (cls_d),
      .hit       (hit_d)
   );

   assign gate_ok = (!eof_runt || mode_q[MB_RUNT]) && (!eof_err || mode_q[MB_ERR]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q        <= '0;
         da_q         <= '0;
         crc_q        <= CRC_SEED;
         mode_q       <= '0;
         tbl_q        <= '0;
         sta_q        <= '0;
         addr_valid   <= 1'b0;
         addr_hit     <= 1'b0;
         cls_bcast    <= 1'b0;
         cls_phys     <= 1'b0;
         cls_mcast    <= 1'b0;
         frame_done   <= 1'b0;
         frame_accept <= 1'b0;
      end else if (sof) begin
         cnt_q        <= '0;
         da_q         <= '0;
         crc_q        <= CRC_SEED;
         mode_q       <= accept_mode;
         tbl_q        <= {hash_word1, hash_word0};
         sta_q        <= station_addr;
         addr_valid   <= 1'b0;
         addr_hit     <= 1'b0;
         cls_bcast    <= 1'b0;
         cls_phys     <= 1'b0;
         cls_mcast    <= 1'b0;
         frame_done   <= 1'b0;
         frame_accept <= 1'b0;
      end else begin
         if (take) begin
            da_q  <= da_next;
            crc_q <= crc_next;
            cnt_q <= cnt_q + 1'b1;
         end
         if (last) begin
            addr_valid <= 1'b1;
            addr_hit   <= hit_d;
            cls_bcast  <= cls_d.bcast;
            cls_phys   <= cls_d.phys;
            cls_mcast  <= cls_d.mcast;
         end
         if (eof && !frame_done) begin
            frame_done   <= 1'b1;
            frame_accept <= addr_valid && addr_hit && gate_ok;
         end
      end
   end

   AST_VERDICT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> addr_valid) else $error("AST_VERDICT_TIMING"); // R2
   AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !sof) |=> (addr_valid && $stable(addr_hit) && $stable(cls_mcast)))
      else $error("AST_VERDICT_HOLD"); // R2
   AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> (!addr_valid && !frame_done && !frame_accept))
      else $error("AST_SOF_CLEARS"); // R11
   AST_RUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (eof && !sof && !frame_done && eof_runt && !mode_q[MB_RUNT]) |=> !frame_accept)
      else $error("AST_RUNT_DROP"); // R8
   AST_ERR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (eof && !sof && !frame_done && eof_err && !mode_q[MB_ERR]) |=> !frame_accept)
      else $error("AST_ERR_DROP"); // R9
   AST_ACCEPT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_accept |-> (frame_done && addr_valid && addr_hit))
      else $error("AST_ACCEPT_NEEDS_HIT"); // R10
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sof = 1'b0, da_valid = 1'b0, eof = 1'b0, eof_runt = 1'b0, eof_err = 1'b0;
   logic [7:0]  da_byte = '0;
   logic [47:0] station_addr = 48'h0;
   logic [31:0] hash_word0 = '0, hash_word1 = '0;
   logic [5:0]  accept_mode = '0;
   logic addr_valid, addr_hit, cls_bcast, cls_phys, cls_mcast, frame_done, frame_accept;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   rx_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .sof(sof), .da_valid(da_valid), .da_byte(da_byte),
      .eof(eof), .eof_runt(eof_runt), .eof_err(eof_err), .station_addr(station_addr),
      .hash_word0(hash_word0), .hash_word1(hash_word1), .accept_mode(accept_mode),
      .addr_valid(addr_valid), .addr_hit(addr_hit), .cls_bcast(cls_bcast),
      .cls_phys(cls_phys), .cls_mcast(cls_mcast), .frame_done(frame_done),
      .frame_accept(frame_accept)
   );

   localparam logic [47:0] STA  = 48'h5A_4C_3E_1D_22_02;
   localparam logic [47:0] BC   = 48'hFFFF_FFFF_FFFF;
   localparam logic [47:0] UCX  = 48'h10_20_30_40_50_60;
   localparam logic [47:0] MCA  = 48'h01_00_5E_00_00_01;
   localparam logic [47:0] MCB  = 48'hFB_00_00_5E_00_01;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] hidx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         c = c ^ {24'h0, a[8*b +: 8]};
         for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return c[31:26];
   endfunction

   function automatic logic exp_hit(input logic [47:0] a, input logic [5:0] m,
                                    input logic [63:0] t, input logic [47:0] s);
      logic bc = &a;
      logic mc = a[0] && !bc;
      logic uc = !a[0];
      return (bc && m[3]) || (mc && m[2] && t[hidx(a)]) || (uc && (m[0] || (m[1] && a == s)));
   endfunction

   task automatic send_addr(input logic [47:0] a);
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
      for (int b = 0; b < 6; b++) begin
         da_valid = 1'b1; da_byte = a[8*b +: 8];
         @(negedge clk);
      end
      da_valid = 1'b0;
   endtask

   task automatic end_frame(input logic r, input logic e);
      eof = 1'b1; eof_runt = r; eof_err = e;
      @(negedge clk);
      eof = 1'b0; eof_runt = 1'b0; eof_err = 1'b0;
   endtask

   task automatic full_check(input logic [47:0] a, input logic r, input logic e,
                             input logic [5:0] m, input logic [63:0] t, input string req);
      logic h;
      h = exp_hit(a, m, t, STA);
      send_addr(a);
      chk({req, " addr_valid"}, addr_valid, 1'b1);
      chk({req, " addr_hit"}, addr_hit, h);
      chk({req, " class"}, {cls_bcast, cls_phys, cls_mcast},
          {&a, (!a[0] && a == STA), (a[0] && !(&a))});
      end_frame(r, e);
      chk({req, " accept"}, {frame_done, frame_accept},
          {1'b1, h && (!r || m[4]) && (!e || m[5])});
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [63:0] tbl;
      string rq;
      station_addr = STA;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {addr_valid, addr_hit, cls_bcast, cls_phys, cls_mcast, frame_done, frame_accept}, 7'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep all modes against each address class and runt/error combination
      tbl = 64'h1 << hidx(MCA);
      hash_word0 = tbl[31:0]; hash_word1 = tbl[63:32];
      for (int m = 0; m < 64; m++) begin
         accept_mode = 6'(m);
         for (int ai = 0; ai < 5; ai++) begin
            logic [47:0] a;
            a = (ai == 0) ? BC : (ai == 1) ? STA : (ai == 2) ? UCX : (ai == 3) ? MCA : MCB;
            for (int re = 0; re < 4; re++) begin
               if (re[0]) rq = "R8";
               else if (re[1]) rq = "R9";
               else if (ai == 0) rq = "R3";
               else if (ai >= 3) rq = "R4";
               else rq = "R7";
               full_check(a, re[0], re[1], 6'(m), tbl, rq);
            end
         end
      end

      // Exact hash index: only the index bit set, then all bits but it
      accept_mode = 6'b000100;
      for (int i = 0; i < 6; i++) begin
         logic [47:0] a;
         a = {8'(i * 37 + 11), 8'(i * 5), 8'h9C, 8'(i), 8'h42, 8'(2 * i + 1)};
         tbl = 64'h1 << hidx(a);
         hash_word0 = tbl[31:0]; hash_word1 = tbl[63:32];
         full_check(a, 1'b0, 1'b0, accept_mode, tbl, "R5 only-bit");
         tbl = ~tbl;
         hash_word0 = tbl[31:0]; hash_word1 = tbl[63:32];
         full_check(a, 1'b0, 1'b0, accept_mode, tbl, "R5 all-but-bit");
      end

      // All-multicast table
      tbl = '1; hash_word0 = '1; hash_word1 = '1;
      for (int i = 0; i < 8; i++) begin
         logic [47:0] a;
         a = {8'(i * 29), 8'h33, 8'(i), 8'h77, 8'(i * 3), 8'(4 * i + 1)};
         full_check(a, 1'b0, 1'b0, 6'b000100, tbl, "R6");
      end

      // Configuration change inside a frame has no effect on it
      accept_mode = 6'b001000;
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0; accept_mode = 6'b000000;
      for (int b = 0; b < 6; b++) begin
         da_valid = 1'b1; da_byte = 8'hFF; @(negedge clk);
      end
      da_valid = 1'b0;
      chk("R11 mid-frame mode change", addr_hit, 1'b1);
      // Seventh byte ignored, verdict held
      da_valid = 1'b1; da_byte = 8'h00;
      @(negedge clk); da_valid = 1'b0;
      chk("R2 extra byte ignored", {addr_valid, addr_hit, cls_bcast}, 3'b111);
      end_frame(1'b0, 1'b0);
      chk("R11 frame accept", frame_accept, 1'b1);
      @(negedge clk);
      chk("R10 verdict holds", {frame_done, frame_accept}, 2'b11);

      // Byte-order: station bytes reversed must not match
      accept_mode = 6'b000010;
      full_check({STA[7:0], STA[15:8], STA[23:16], STA[31:24], STA[39:32], STA[47:40]},
                 1'b0, 1'b0, accept_mode, tbl, "R2 byte order");

      // Early end of frame before address verdict
      accept_mode = 6'b111111;
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
      for (int b = 0; b < 3; b++) begin
         da_valid = 1'b1; da_byte = 8'hFF; @(negedge clk);
      end
      da_valid = 1'b0;
      chk("R2 no verdict before sixth byte", addr_valid, 1'b0);
      end_frame(1'b0, 1'b0);
      chk("R10 early eof", {frame_done, frame_accept}, 2'b10);
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
      chk("R11 sof clears", {addr_valid, frame_done, frame_accept}, 3'b000);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule